// File: doc/BRIEF.md
# Puzzle Module Registry and Game State Aggregator

This block sits in the central controller of a modular puzzle game. After reset it walks a configurable range of bus addresses and sends a handshake request to each one. Any address that answers the handshake within a fixed number of cycles is added to a registry. Once the walk is over, the block keeps polling every registered module for its game state, one after another, from the highest address down. Each poll carries the controller's current overall state, so every module learns when the whole box is solved.

The overall state is derived from the stored module states and is never written from outside. When no module is registered, or every module is idle, the overall state is idle. When every module is solved, it is solved. In all other cases it is playing. A module that has not yet answered a state poll still counts as uninitialized. The block also reports which puzzle is current: the highest registered address that is not yet solved. Requests that reach the controller from the bus are answered with a response of the same type. Write messages are dropped.

Messages move through an abstract valid/ready port on the transmit side and a valid-only port on the receive side. Each message carries a type, an action, a sender address, a destination and a 2-bit state payload. The physical bus, serialization and any network bridge are outside this block.

Top module: `puzzle_registry`

## Requirements
- R1: After reset, the block sends a handshake request (type 0, action 0) to each address from SCAN_LAST down to SCAN_FIRST, one at a time. It skips its own address OWN_ADDR. A handshake response (type 0, action 1) from the addressed module within TIMEOUT cycles registers that address; otherwise the scan moves on. `scan_done` then rises and `mod_count` holds the number of registered modules.
- R2: After the scan, state requests (type 1, action 0) go only to registered addresses, in descending order, and wrap from the lowest back to the highest without end. Each request's `tx_state` equals `agg_state`.
- R3: States are encoded 0 uninitialized, 1 idle, 2 playing, 3 solved. `agg_state` is 1 when all registered modules are idle, 3 when all are solved, and 2 otherwise (this includes a mix of idle and solved).
- R4: With no module registered, `agg_state` is 1 (idle) and `play_valid` is 0.
- R5: `play_addr` is the highest registered address whose stored state is not 3, and `play_valid` marks that such an address exists.
- R6: A received request (action 0) of any type (0 handshake, 1 state, 2 property) is answered on the next cycle. The answer has action 1, the same type, destination equal to the request's sender, sender field OWN_ADDR and payload `agg_state`. It takes priority over polls.
- R7: A received set message (action 2) of any type, including a state set aimed at the controller, produces no response and leaves `agg_state` unchanged.
- R8: A state response (type 1, action 1) from a registered sender updates that module's stored state on the next cycle. One from an unregistered sender is ignored.
- R9: A registered module that has not yet reported (state 0) counts as neither idle nor solved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | output | 1 | Outgoing message valid |
| tx_ready | input | 1 | Outgoing message accepted |
| tx_type | output | 2 | Outgoing type: 0 handshake, 1 state, 2 property |
| tx_action | output | 2 | Outgoing action: 0 request, 1 response, 2 set |
| tx_sender | output | ADDR_W | Own address |
| tx_dest | output | ADDR_W | Destination address |
| tx_state | output | 2 | Payload: current aggregate state |
| rx_valid | input | 1 | Incoming message valid |
| rx_type | input | 2 | Incoming type |
| rx_action | input | 2 | Incoming action |
| rx_sender | input | ADDR_W | Incoming sender address |
| rx_state | input | 2 | Incoming state payload |
| scan_done | output | 1 | Handshake scan finished |
| mod_count | output | CNT_W | Number of registered modules |
| agg_state | output | 2 | Aggregate game state |
| play_valid | output | 1 | An unsolved registered module exists |
| play_addr | output | ADDR_W | Highest unsolved registered address |

## Verification
The bench models three answering modules and places the controller's own address inside the scan range. A scan that polled itself, or that walked addresses in the wrong direction, would send a handshake with an unexpected destination. Right after the scan, all registered modules are still uninitialized. A design that treated state 0 as idle would report idle there instead of playing. A table of module state mixes covers the all-idle and all-solved rules and the idle/solved mix that must give playing. The bench then injects requests, set messages, and state responses from both registered and unregistered senders. A design that answered a set, stored a state from an unknown sender, or let a state write override the derived value would show the wrong aggregate or a stray response.

// File: rtl/puzzle_registry_pkg.sv
package puzzle_registry_pkg;

   typedef enum logic [1:0] {
      MT_MAGIC = 2'd0,
      MT_STATE = 2'd1,
      MT_PROP  = 2'd2
   } msg_type_e;

   typedef enum logic [1:0] {
      AC_REQ = 2'd0,
      AC_RES = 2'd1,
      AC_SET = 2'd2
   } msg_act_e;

   typedef enum logic [1:0] {
      GS_UNINIT  = 2'd0,
      GS_IDLE    = 2'd1,
      GS_PLAYING = 2'd2,
      GS_SOLVED  = 2'd3
   } game_state_e;

   typedef enum logic [2:0] {
      SQ_SCAN_TX,
      SQ_SCAN_WAIT,
      SQ_POLL_PICK,
      SQ_POLL_TX,
      SQ_POLL_WAIT
   } seq_state_e;

endpackage

// File: rtl/pz_sequencer.sv
module pz_sequencer
   import puzzle_registry_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int SCAN_FIRST = 8,
   parameter int SCAN_LAST  = 119,
   parameter int TIMEOUT    = 16,
   parameter int OWN_ADDR   = 16,
   localparam int NADDR     = 1 << ADDR_W,
   localparam int TMR_W     = $clog2(TIMEOUT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NADDR-1:0]  present,
   input  logic              grant,
   input  logic              rx_valid,
   input  logic [1:0]        rx_type,
   input  logic [1:0]        rx_action,
   input  logic [ADDR_W-1:0] rx_sender,
   output logic              req_valid,
   output logic [1:0]        req_type,
   output logic [ADDR_W-1:0] req_dest,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              scan_done
);

   localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(SCAN_FIRST);
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(SCAN_LAST);
   localparam logic [ADDR_W-1:0] OWN_A   = ADDR_W'(OWN_ADDR);
   localparam logic [TMR_W-1:0]  TMO_END = TMR_W'(TIMEOUT - 1);

   seq_state_e        st_q, st_d;
   logic [ADDR_W-1:0] cur_q, cur_d, cur_dn;
   logic [TMR_W-1:0]  tmr_q, tmr_d;
   logic              done_q, done_d;
   logic              hit, tmo, scan_adv, poll_adv;

   assign cur_dn = (cur_q == FIRST_A) ? LAST_A : cur_q - 1'b1;
   assign hit    = rx_valid && (rx_action == AC_RES) && (rx_sender == cur_q);
   assign tmo    = (tmr_q == TMO_END);

   always_comb begin
      st_d      = st_q;
      cur_d     = cur_q;
      tmr_d     = tmr_q;
      done_d    = done_q;
      req_valid = 1'b0;
      req_type  = MT_MAGIC;
      reg_we    = 1'b0;
      scan_adv  = 1'b0;
      poll_adv  = 1'b0;
      case (st_q)
         SQ_SCAN_TX: begin
            if (cur_q == OWN_A) begin
               scan_adv = 1'b1;
            end else begin
               req_valid = 1'b1;
               if (grant) begin
                  st_d  = SQ_SCAN_WAIT;
                  tmr_d = '0;
               end
            end
         end
         SQ_SCAN_WAIT: begin
            if (hit && (rx_type == MT_MAGIC)) begin
               reg_we   = 1'b1;
               scan_adv = 1'b1;
            end else if (tmo) begin
               scan_adv = 1'b1;
            end else begin
               tmr_d = tmr_q + 1'b1;
            end
         end
         SQ_POLL_PICK: begin
            if (present[cur_q]) st_d = SQ_POLL_TX;
            else                poll_adv = 1'b1;
         end
         SQ_POLL_TX: begin
            req_valid = 1'b1;
            req_type  = MT_STATE;
            if (grant) begin
               st_d  = SQ_POLL_WAIT;
               tmr_d = '0;
            end
         end
         SQ_POLL_WAIT: begin
            if ((hit && (rx_type == MT_STATE)) || tmo) poll_adv = 1'b1;
            else                                       tmr_d = tmr_q + 1'b1;
         end
         default: st_d = SQ_SCAN_TX;
      endcase
      if (scan_adv) begin
         if (cur_q == FIRST_A) begin
            done_d = 1'b1;
            cur_d  = LAST_A;
            st_d   = SQ_POLL_PICK;
         end else begin
            cur_d = cur_q - 1'b1;
            st_d  = SQ_SCAN_TX;
         end
      end
      if (poll_adv) begin
         cur_d = cur_dn;
         st_d  = SQ_POLL_PICK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_SCAN_TX;
         cur_q  <= LAST_A;
         tmr_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cur_q  <= cur_d;
         tmr_q  <= tmr_d;
         done_q <= done_d;
      end
   end

   assign req_dest  = cur_q;
   assign reg_addr  = cur_q;
   assign scan_done = done_q;

endmodule

// File: rtl/pz_table.sv
module pz_table
   import puzzle_registry_pkg::*;
#(
   parameter int ADDR_W = 7,
   localparam int NADDR = 1 << ADDR_W,
   localparam int CNT_W = $clog2(NADDR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              rx_valid,
   input  logic [1:0]        rx_type,
   input  logic [1:0]        rx_action,
   input  logic [ADDR_W-1:0] rx_sender,
   input  logic [1:0]        rx_state,
   output logic [NADDR-1:0]  present,
   output logic [CNT_W-1:0]  mod_count,
   output logic [1:0]        agg_state,
   output logic              play_valid,
   output logic [ADDR_W-1:0] play_addr
);

   logic [NADDR-1:0] present_q;
   logic [1:0]       st_q [NADDR];
   logic [CNT_W-1:0] cnt_q;
   logic [NADDR-1:0] idle_ok, solv_ok, open_v;
   logic             st_wr;

   assign st_wr = rx_valid && (rx_type == MT_STATE) && (rx_action == AC_RES)
                  && present_q[rx_sender];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         present_q <= '0;
         cnt_q     <= '0;
         for (int a = 0; a < NADDR; a++) st_q[a] <= GS_UNINIT;
      end else begin
         if (reg_we && !present_q[reg_addr]) begin
            present_q[reg_addr] <= 1'b1;
            cnt_q               <= cnt_q + 1'b1;
         end
         if (st_wr) st_q[rx_sender] <= rx_state;
      end
   end

   for (genvar a = 0; a < NADDR; a++) begin : g_slot
      assign idle_ok[a] = !present_q[a] || (st_q[a] == GS_IDLE);
      assign solv_ok[a] = !present_q[a] || (st_q[a] == GS_SOLVED);
      assign open_v[a]  = present_q[a] && (st_q[a] != GS_SOLVED);
   end

   always_comb begin
      if (!(|present_q) || (&idle_ok)) agg_state = GS_IDLE;
      else if (&solv_ok)               agg_state = GS_SOLVED;
      else                             agg_state = GS_PLAYING;
   end

   always_comb begin
      play_addr = '0;
      for (int a = 0; a < NADDR; a++) begin
         if (open_v[a]) play_addr = ADDR_W'(a);
      end
   end

   assign play_valid = |open_v;
   assign present    = present_q;
   assign mod_count  = cnt_q;

endmodule

// File: rtl/pz_reply.sv
module pz_reply
   import puzzle_registry_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [1:0]        rx_type,
   input  logic [1:0]        rx_action,
   input  logic [ADDR_W-1:0] rx_sender,
   input  logic              tx_ready,
   output logic              rep_pend,
   output logic [1:0]        rep_type,
   output logic [ADDR_W-1:0] rep_dest
);

   logic take;
   assign take = rx_valid && (rx_action == AC_REQ);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rep_pend <= 1'b0;
         rep_type <= MT_MAGIC;
         rep_dest <= '0;
      end else if (take) begin
         rep_pend <= 1'b1;
         rep_type <= rx_type;
         rep_dest <= rx_sender;
      end else if (rep_pend && tx_ready) begin
         rep_pend <= 1'b0;
      end
   end

endmodule

// File: rtl/puzzle_registry.sv
module puzzle_registry
   import puzzle_registry_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int SCAN_FIRST = 8,
   parameter int SCAN_LAST  = 119,
   parameter int TIMEOUT    = 16,
   parameter int OWN_ADDR   = 16,
   localparam int NADDR     = 1 << ADDR_W,
   localparam int CNT_W     = $clog2(NADDR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [1:0]        tx_type,
   output logic [1:0]        tx_action,
   output logic [ADDR_W-1:0] tx_sender,
   output logic [ADDR_W-1:0] tx_dest,
   output logic [1:0]        tx_state,
   input  logic              rx_valid,
   input  logic [1:0]        rx_type,
   input  logic [1:0]        rx_action,
   input  logic [ADDR_W-1:0] rx_sender,
   input  logic [1:0]        rx_state,
   output logic              scan_done,
   output logic [CNT_W-1:0]  mod_count,
   output logic [1:0]        agg_state,
   output logic              play_valid,
   output logic [ADDR_W-1:0] play_addr
);

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_width
      $error("puzzle_registry: ADDR_W out of range");
   end
   if (SCAN_FIRST < 0 || SCAN_FIRST > SCAN_LAST || SCAN_LAST >= NADDR) begin : g_bad_range
      $error("puzzle_registry: scan range invalid");
   end
   if (TIMEOUT < 1) begin : g_bad_tmo
      $error("puzzle_registry: TIMEOUT must be at least 1");
   end
   if (OWN_ADDR < 0 || OWN_ADDR >= NADDR) begin : g_bad_own
      $error("puzzle_registry: OWN_ADDR out of range");
   end

   logic [NADDR-1:0]  present;
   logic              req_valid, reg_we, rep_pend, grant;
   logic [1:0]        req_type, rep_type;
   logic [ADDR_W-1:0] req_dest, reg_addr, rep_dest;

   assign grant = tx_ready && !rep_pend;

   pz_sequencer #(
      .ADDR_W(ADDR_W), .SCAN_FIRST(SCAN_FIRST), .SCAN_LAST(SCAN_LAST),
      .TIMEOUT(TIMEOUT), .OWN_ADDR(OWN_ADDR)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .present(present), .grant(grant),
      .rx_valid(rx_valid), .rx_type(rx_type), .rx_action(rx_action),
      .rx_sender(rx_sender), .req_valid(req_valid), .req_type(req_type),
      .req_dest(req_dest), .reg_we(reg_we), .reg_addr(reg_addr),
      .scan_done(scan_done)
   );

   pz_table #(.ADDR_W(ADDR_W)) u_tab (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .rx_valid(rx_valid), .rx_type(rx_type), .rx_action(rx_action),
      .rx_sender(rx_sender), .rx_state(rx_state), .present(present),
      .mod_count(mod_count), .agg_state(agg_state),
      .play_valid(play_valid), .play_addr(play_addr)
   );

   pz_reply #(.ADDR_W(ADDR_W)) u_rep (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_type(rx_type),
      .rx_action(rx_action), .rx_sender(rx_sender), .tx_ready(tx_ready),
      .rep_pend(rep_pend), .rep_type(rep_type), .rep_dest(rep_dest)
   );

   assign tx_valid  = rep_pend || req_valid;
   assign tx_type   = rep_pend ? rep_type : req_type;
   assign tx_action = rep_pend ? AC_RES : AC_REQ;
   assign tx_dest   = rep_pend ? rep_dest : req_dest;
   assign tx_sender = ADDR_W'(OWN_ADDR);
   assign tx_state  = agg_state;

endmodule

// File: rtl/puzzle_registry_chk.sv
module puzzle_registry_chk #(
   parameter int ADDR_W   = 7,
   parameter int OWN_ADDR = 16,
   parameter int CNT_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [1:0]        tx_type,
   input logic [1:0]        tx_action,
   input logic [ADDR_W-1:0] tx_dest,
   input logic [1:0]        tx_state,
   input logic              rx_valid,
   input logic [1:0]        rx_type,
   input logic [1:0]        rx_action,
   input logic [ADDR_W-1:0] rx_sender,
   input logic              scan_done,
   input logic [CNT_W-1:0]  mod_count,
   input logic [1:0]        agg_state,
   input logic              play_valid
);

   p_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_action == 2'd0) |=>
         (tx_valid && tx_action == 2'd1 && tx_type == $past(rx_type)
          && tx_dest == $past(rx_sender)));

   p_set_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_action == 2'd2 && !(tx_valid && tx_action == 2'd1)) |=>
         !(tx_valid && tx_action == 2'd1));

   p_skip_own_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_type == 2'd0 && tx_action == 2'd0) |-> tx_dest != ADDR_W'(OWN_ADDR));

   p_count_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> (scan_done && $stable(mod_count)));

   p_hold_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !(rx_valid && rx_action == 2'd0)) |=>
         (tx_valid && $stable(tx_dest) && $stable(tx_type) && $stable(tx_action)));

   p_poll_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_type == 2'd1 && tx_action == 2'd0) |-> tx_state == agg_state);

   p_empty_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_count == '0) |-> (agg_state == 2'd1 && !play_valid));

   p_all_solved_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!play_valid && mod_count != '0) |-> agg_state == 2'd3);

endmodule

bind puzzle_registry puzzle_registry_chk #(
   .ADDR_W(ADDR_W), .OWN_ADDR(OWN_ADDR), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
   .tx_type(tx_type), .tx_action(tx_action), .tx_dest(tx_dest),
   .tx_state(tx_state), .rx_valid(rx_valid), .rx_type(rx_type),
   .rx_action(rx_action), .rx_sender(rx_sender), .scan_done(scan_done),
   .mod_count(mod_count), .agg_state(agg_state), .play_valid(play_valid)
);

// File: tb/puzzle_registry_tb.sv
`timescale 1ns/1ps
module puzzle_registry_tb_top;

   localparam int ADDR_W = 7;
   localparam int S_FIRST = 8;
   localparam int S_LAST = 31;
   localparam int TMO = 6;
   localparam int OWN = 16;
   localparam int CNT_W = $clog2((1 << ADDR_W) + 1);

   // vector: {state28, state20, state12, exp_agg, exp_play_valid, exp_play_addr}
   localparam logic [15:0] VEC [7] = '{
      {2'd1, 2'd1, 2'd1, 2'd1, 1'b1, 7'd28},
      {2'd2, 2'd1, 2'd1, 2'd2, 1'b1, 7'd28},
      {2'd3, 2'd2, 2'd1, 2'd2, 1'b1, 7'd20},
      {2'd3, 2'd3, 2'd2, 2'd2, 1'b1, 7'd12},
      {2'd3, 2'd3, 2'd3, 2'd3, 1'b0, 7'd0},
      {2'd1, 2'd3, 2'd1, 2'd2, 1'b1, 7'd28},
      {2'd3, 2'd1, 2'd3, 2'd2, 1'b1, 7'd20}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_valid, tx_ready;
   logic [1:0] tx_type, tx_action, tx_state;
   logic [ADDR_W-1:0] tx_sender, tx_dest;
   logic rx_valid = 1'b0;
   logic [1:0] rx_type = 2'd0, rx_action = 2'd0, rx_state = 2'd0;
   logic [ADDR_W-1:0] rx_sender = '0;
   logic scan_done, play_valid;
   logic [CNT_W-1:0] mod_count;
   logic [1:0] agg_state;
   logic [ADDR_W-1:0] play_addr;

   int n_chk = 0;
   int n_fail = 0;
   logic mod_here [128];
   logic [1:0] mod_st [128];
   int exp_scan = S_LAST;
   int last_poll = S_FIRST;

   always #5 clk = ~clk;

   puzzle_registry #(
      .ADDR_W(ADDR_W), .SCAN_FIRST(S_FIRST), .SCAN_LAST(S_LAST),
      .TIMEOUT(TMO), .OWN_ADDR(OWN)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_type(tx_type), .tx_action(tx_action), .tx_sender(tx_sender),
      .tx_dest(tx_dest), .tx_state(tx_state), .rx_valid(rx_valid),
      .rx_type(rx_type), .rx_action(rx_action), .rx_sender(rx_sender),
      .rx_state(rx_state), .scan_done(scan_done), .mod_count(mod_count),
      .agg_state(agg_state), .play_valid(play_valid), .play_addr(play_addr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int next_poll(input int last);
      for (int a = last - 1; a >= S_FIRST; a--) if (mod_here[a]) return a;
      for (int a = S_LAST; a >= S_FIRST; a--) if (mod_here[a]) return a;
      return -1;
   endfunction

   // module models: answer handshakes and state polls one cycle after acceptance
   initial begin
      logic due, drove;
      logic [1:0] d_type, d_st;
      int d_src;
      due = 1'b0; drove = 1'b0; d_type = 2'd0; d_st = 2'd0; d_src = 0;
      forever begin
         @(negedge clk);
         #1;
         if (due) begin
            rx_valid = 1'b1; rx_type = d_type; rx_action = 2'd1;
            rx_sender = ADDR_W'(d_src); rx_state = d_st;
            due = 1'b0; drove = 1'b1;
         end else if (drove) begin
            rx_valid = 1'b0; drove = 1'b0;
         end
         if (rst_n && tx_valid && tx_ready && tx_action == 2'd0) begin
            if (tx_type == 2'd0) begin
               chk("R1", "handshake destination", int'(tx_dest), exp_scan);
               exp_scan--;
               if (exp_scan == OWN) exp_scan--;
               if (mod_here[tx_dest]) begin
                  due = 1'b1; d_type = 2'd0; d_src = int'(tx_dest); d_st = 2'd0;
               end
            end else if (tx_type == 2'd1) begin
               chk("R2", "poll destination", int'(tx_dest), next_poll(last_poll));
               chk("R2", "poll payload", int'(tx_state), int'(agg_state));
               last_poll = int'(tx_dest);
               if (mod_here[tx_dest]) begin
                  if (mod_st[tx_dest] == 2'd0) mod_st[tx_dest] = 2'd1;
                  due = 1'b1; d_type = 2'd1; d_src = int'(tx_dest);
                  d_st = mod_st[tx_dest];
               end
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   task automatic inject(input int typ, input int act, input int src, input int st);
      rx_valid = 1'b1; rx_type = 2'(typ); rx_action = 2'(act);
      rx_sender = ADDR_W'(src); rx_state = 2'(st);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      for (int a = 0; a < 128; a++) begin mod_here[a] = 1'b0; mod_st[a] = 2'd0; end
      mod_here[28] = 1'b1; mod_here[20] = 1'b1; mod_here[12] = 1'b1;
      tx_ready = 1'b1;
      repeat (3) @(negedge clk);
      // R4: empty registry in reset
      chk("R4", "reset agg_state", int'(agg_state), 1);
      chk("R4", "reset play_valid", int'(play_valid), 0);
      chk("R1", "reset mod_count", int'(mod_count), 0);
      chk("R1", "reset scan_done", int'(scan_done), 0);
      rst_n = 1'b1;

      while (!scan_done) @(negedge clk);
      chk("R1", "registered count", int'(mod_count), 3);
      chk("R1", "scan covered range", exp_scan, S_FIRST - 1);
      chk("R9", "uninitialized modules give playing", int'(agg_state), 2);
      chk("R5", "play address while uninitialized", int'(play_addr), 28);

      repeat (120) @(negedge clk);
      chk("R3", "all idle after first polls", int'(agg_state), 1);

      for (int v = 0; v < 7; v++) begin
         mod_st[28] = VEC[v][15:14];
         mod_st[20] = VEC[v][13:12];
         mod_st[12] = VEC[v][11:10];
         repeat (120) @(negedge clk);
         chk("R3", $sformatf("vector %0d agg_state", v), int'(agg_state), int'(VEC[v][9:8]));
         chk("R5", $sformatf("vector %0d play_valid", v), int'(play_valid), int'(VEC[v][7]));
         if (VEC[v][7])
            chk("R5", $sformatf("vector %0d play_addr", v), int'(play_addr), int'(VEC[v][6:0]));
      end

      // stall the bus so module models stay silent
      tx_ready = 1'b0;
      repeat (4) @(negedge clk);
      inject(1, 0, 28, 0);
      chk("R6", "state reply valid", int'(tx_valid), 1);
      chk("R6", "state reply action", int'(tx_action), 1);
      chk("R6", "state reply type", int'(tx_type), 1);
      chk("R6", "state reply dest", int'(tx_dest), 28);
      chk("R6", "reply sender", int'(tx_sender), OWN);
      chk("R6", "reply payload", int'(tx_state), 2);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      chk("R6", "reply drained", int'(tx_valid && tx_action == 2'd1), 0);

      inject(2, 0, 20, 0);
      chk("R6", "property reply type", int'(tx_type), 2);
      chk("R6", "property reply dest", int'(tx_dest), 20);
      chk("R6", "property reply action", int'(tx_action), 1);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;

      inject(1, 2, 28, 3);
      chk("R7", "no reply to state set", int'(tx_valid && tx_action == 2'd1), 0);
      chk("R7", "state set leaves aggregate", int'(agg_state), 2);
      inject(2, 2, 20, 1);
      chk("R7", "no reply to property set", int'(tx_valid && tx_action == 2'd1), 0);

      inject(1, 1, 20, 3);
      chk("R8", "registered state response stored", int'(agg_state), 3);
      chk("R8", "play_valid after all solved", int'(play_valid), 0);
      inject(1, 1, 24, 1);
      chk("R8", "unregistered response ignored", int'(agg_state), 3);

      tx_ready = 1'b1;
      repeat (120) @(negedge clk);
      chk("R8", "poll restores reported state", int'(agg_state), 2);
      chk("R5", "play address after restore", int'(play_addr), 20);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule